// File: doc/BRIEF.md
# Execute-Stage Operand Forwarding Unit

This block sits at the entrance of the execute stage of a five-stage in-order pipeline and decides, separately for each of the two ALU operands, where the operand's value comes from. There are three candidates for each operand:

- the register-file value captured in the decode/execute register;
- the ALU result now held in the execute/memory register;
- the final writeback value in the memory/writeback register.

A later-stage result is used when that stage is going to write the register the operand names. This lets a dependent instruction run without waiting for the write to reach the register file.

When both later stages target the operand's register, the execute/memory result is taken, because it belongs to the younger producer. Register 0 is hard-wired and never forwarded. The block is purely combinational: each forwarded value and its select code follow the inputs in the same cycle. Stall generation, the load-use case and the bypass inside the register file are handled elsewhere.

Top module: `exec_operand_fwd`

## Requirements
- R1: An operand takes the execute/memory ALU result, with select code 2'b10, when `xm_wr_en` is 1, `xm_dst_idx` is nonzero and `xm_dst_idx` equals that operand's source index.
- R2: An operand takes the memory/writeback value, with select code 2'b01, when `mw_wr_en` is 1, `mw_dst_idx` is nonzero, `mw_dst_idx` equals the operand's source index and the R1 condition for that operand is false.
- R3: Operand B is decided by the same rules as operand A, using only its own source index, so that A and B may select different sources in the same cycle.
- R4: A stage whose destination index is 0 never supplies a forwarded value: with both destinations 0, both select codes are 2'b00.
- R5: When neither forwarding condition holds, the select code is 2'b00 and the operand equals its register-file input.
- R6: When both later stages write the operand's register, select code 2'b10 and the execute/memory data win over the writeback data.
- R7: A stage whose write enable is 0 never supplies a forwarded value, even when its destination matches.
- R8: The outputs depend only on the present inputs, with no register inside, so a change of inputs is visible in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a_idx | input | 3 | Source register index of operand A (decode/execute) |
| src_b_idx | input | 3 | Source register index of operand B (decode/execute) |
| rf_a_data | input | 32 | Register-file value read for operand A |
| rf_b_data | input | 32 | Register-file value read for operand B |
| xm_wr_en | input | 1 | Execute/memory stage will write a register |
| xm_dst_idx | input | 3 | Destination index held in execute/memory |
| xm_alu_data | input | 32 | ALU result held in execute/memory |
| mw_wr_en | input | 1 | Memory/writeback stage will write a register |
| mw_dst_idx | input | 3 | Destination index held in memory/writeback |
| mw_wb_data | input | 32 | Final writeback value in memory/writeback |
| opnd_a_data | output | 32 | Operand A value presented to the ALU |
| opnd_b_data | output | 32 | Operand B value presented to the ALU |
| opnd_a_sel | output | 2 | Source of operand A: 00 register file, 10 execute/memory, 01 writeback |
| opnd_b_sel | output | 2 | Source of operand B, same encoding |

## Verification
The assertions assume that every input is at a defined 0 or 1 level whenever the combinational logic settles, and that a select code of 2'b11 never arises, since no input combination maps to it. The bench drives every input once per cycle, just after the rising edge. Directed cases cover a back-to-back dependency, a dependency at distance two, and the case where both stages write one register. Randomized cycles then draw indices from the full eight-register range, so that matches, register-0 destinations and disabled writes occur often.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    localparam int FWD_DATA_W = 32;
    localparam int FWD_IDX_W  = 3;
    localparam int FWD_NUM_OPND = 2;

    // Operand source codes; bit 1 flags the younger stage, bit 0 the older one.
    typedef enum logic [1:0] {
        SRC_REGFILE = 2'b00,
        SRC_WBACK   = 2'b01,
        SRC_EXMEM   = 2'b10
    } opnd_src_e;

    // Fixed priority: the younger producer overrides the older one.
    function automatic opnd_src_e pick_source(input logic hit_young, input logic hit_old);
        opnd_src_e s;
        if (hit_young)
            s = SRC_EXMEM;
        else if (hit_old)
            s = SRC_WBACK;
        else
            s = SRC_REGFILE;
        return s;
    endfunction

endpackage

// File: rtl/fwd_hit_detect.sv
module fwd_hit_detect #(
    parameter int IDX_W = fwd_pkg::FWD_IDX_W
) (
    input  logic [IDX_W-1:0] src_idx,
    input  logic             prod_wr_en,
    input  logic [IDX_W-1:0] prod_dst_idx,
    output logic             hit
);
    localparam logic [IDX_W-1:0] HARDWIRED_ZERO = '0;

    logic dst_live;

    always_comb begin
        dst_live = prod_wr_en && (prod_dst_idx != HARDWIRED_ZERO);
        hit      = dst_live && (prod_dst_idx == src_idx);
    end

    always_comb begin
        // R7
        if (!prod_wr_en)
            r7_disabled_stage_chk: assert (!hit);
    end

endmodule

// File: rtl/fwd_operand_mux.sv
module fwd_operand_mux #(
    parameter int DATA_W = fwd_pkg::FWD_DATA_W,
    parameter int IDX_W  = fwd_pkg::FWD_IDX_W
) (
    input  logic [IDX_W-1:0]  src_idx,
    input  logic [DATA_W-1:0] rf_data,
    input  logic              xm_wr_en,
    input  logic [IDX_W-1:0]  xm_dst_idx,
    input  logic [DATA_W-1:0] xm_data,
    input  logic              mw_wr_en,
    input  logic [IDX_W-1:0]  mw_dst_idx,
    input  logic [DATA_W-1:0] mw_data,
    output logic [DATA_W-1:0] opnd_data,
    output logic [1:0]        opnd_sel
);
    import fwd_pkg::*;

    logic      hit_xm;
    logic      hit_mw;
    opnd_src_e src;

    fwd_hit_detect #(.IDX_W(IDX_W)) u_hit_xm (
        .src_idx      (src_idx),
        .prod_wr_en   (xm_wr_en),
        .prod_dst_idx (xm_dst_idx),
        .hit          (hit_xm)
    );

    fwd_hit_detect #(.IDX_W(IDX_W)) u_hit_mw (
        .src_idx      (src_idx),
        .prod_wr_en   (mw_wr_en),
        .prod_dst_idx (mw_dst_idx),
        .hit          (hit_mw)
    );

    always_comb begin
        src      = pick_source(hit_xm, hit_mw);
        opnd_sel = src;
        unique case (src)
            SRC_EXMEM: opnd_data = xm_data;
            SRC_WBACK: opnd_data = mw_data;
            default:   opnd_data = rf_data;
        endcase
    end

    always_comb begin
        // R6
        if (hit_xm && hit_mw)
            r6_younger_wins_chk: assert (opnd_sel == 2'b10 && opnd_data == xm_data);
        // R1
        if (opnd_sel == 2'b10)
            r1_exmem_value_chk: assert (opnd_data == xm_data && hit_xm);
        // R2
        if (opnd_sel == 2'b01)
            r2_wback_value_chk: assert (opnd_data == mw_data && hit_mw && !hit_xm);
        // R5
        if (!hit_xm && !hit_mw)
            r5_regfile_pass_chk: assert (opnd_sel == 2'b00 && opnd_data == rf_data);
        sel_code_legal_chk: assert (opnd_sel != 2'b11);
    end

endmodule

// File: rtl/exec_operand_fwd.sv
module exec_operand_fwd #(
    parameter int DATA_W = fwd_pkg::FWD_DATA_W,
    parameter int IDX_W  = fwd_pkg::FWD_IDX_W
) (
    input  logic [IDX_W-1:0]  src_a_idx,
    input  logic [IDX_W-1:0]  src_b_idx,
    input  logic [DATA_W-1:0] rf_a_data,
    input  logic [DATA_W-1:0] rf_b_data,
    input  logic              xm_wr_en,
    input  logic [IDX_W-1:0]  xm_dst_idx,
    input  logic [DATA_W-1:0] xm_alu_data,
    input  logic              mw_wr_en,
    input  logic [IDX_W-1:0]  mw_dst_idx,
    input  logic [DATA_W-1:0] mw_wb_data,
    output logic [DATA_W-1:0] opnd_a_data,
    output logic [DATA_W-1:0] opnd_b_data,
    output logic [1:0]        opnd_a_sel,
    output logic [1:0]        opnd_b_sel
);
    localparam int NUM_OPND = fwd_pkg::FWD_NUM_OPND;

    logic [NUM_OPND-1:0][IDX_W-1:0]  src_idx_v;
    logic [NUM_OPND-1:0][DATA_W-1:0] rf_data_v;
    logic [NUM_OPND-1:0][DATA_W-1:0] opnd_data_v;
    logic [NUM_OPND-1:0][1:0]        opnd_sel_v;

    assign src_idx_v = {src_b_idx, src_a_idx};
    assign rf_data_v = {rf_b_data, rf_a_data};

    // R3: one independent selector per operand
    for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd
        fwd_operand_mux #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_mux (
            .src_idx    (src_idx_v[g]),
            .rf_data    (rf_data_v[g]),
            .xm_wr_en   (xm_wr_en),
            .xm_dst_idx (xm_dst_idx),
            .xm_data    (xm_alu_data),
            .mw_wr_en   (mw_wr_en),
            .mw_dst_idx (mw_dst_idx),
            .mw_data    (mw_wb_data),
            .opnd_data  (opnd_data_v[g]),
            .opnd_sel   (opnd_sel_v[g])
        );
    end

    assign opnd_a_data = opnd_data_v[0];
    assign opnd_b_data = opnd_data_v[1];
    assign opnd_a_sel  = opnd_sel_v[0];
    assign opnd_b_sel  = opnd_sel_v[1];

    always_comb begin
        // R4
        if (xm_dst_idx == '0 && mw_dst_idx == '0)
            r4_zero_dst_chk: assert (opnd_a_sel == 2'b00 && opnd_b_sel == 2'b00);
        // R3
        if (src_a_idx == src_b_idx)
            r3_same_src_agree_chk: assert (opnd_a_sel == opnd_b_sel);
    end

endmodule

// File: tb/tb_exec_operand_fwd.sv
module tb_exec_operand_fwd;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic [2:0]  src_a_idx, src_b_idx, xm_dst_idx, mw_dst_idx;
    logic [31:0] rf_a_data, rf_b_data, xm_alu_data, mw_wb_data;
    logic        xm_wr_en, mw_wr_en;
    logic [31:0] opnd_a_data, opnd_b_data;
    logic [1:0]  opnd_a_sel, opnd_b_sel;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    exec_operand_fwd dut (
        .src_a_idx(src_a_idx), .src_b_idx(src_b_idx),
        .rf_a_data(rf_a_data), .rf_b_data(rf_b_data),
        .xm_wr_en(xm_wr_en), .xm_dst_idx(xm_dst_idx), .xm_alu_data(xm_alu_data),
        .mw_wr_en(mw_wr_en), .mw_dst_idx(mw_dst_idx), .mw_wb_data(mw_wb_data),
        .opnd_a_data(opnd_a_data), .opnd_b_data(opnd_b_data),
        .opnd_a_sel(opnd_a_sel), .opnd_b_sel(opnd_b_sel)
    );

    // Behavioural reference: returns {select, value} for one operand.
    function automatic logic [33:0] model(input int src, input logic [31:0] rf);
        bit young_ok = (xm_wr_en == 1'b1) && (int'(xm_dst_idx) != 0) && (int'(xm_dst_idx) == src);
        bit old_ok   = (mw_wr_en == 1'b1) && (int'(mw_dst_idx) != 0) && (int'(mw_dst_idx) == src);
        if (young_ok) return {2'b10, xm_alu_data};
        if (old_ok)   return {2'b01, mw_wb_data};
        return {2'b00, rf};
    endfunction

    task automatic compare(input string tag);
        logic [33:0] ea = model(int'(src_a_idx), rf_a_data);
        logic [33:0] eb = model(int'(src_b_idx), rf_b_data);
        n_cmp++;
        if ({opnd_a_sel, opnd_a_data} !== ea) begin
            n_bad++;
            $display("FAIL %s operand A: got sel=%b data=%h, expected sel=%b data=%h",
                     tag, opnd_a_sel, opnd_a_data, ea[33:32], ea[31:0]);
        end
        n_cmp++;
        if ({opnd_b_sel, opnd_b_data} !== eb) begin
            n_bad++;
            $display("FAIL %s operand B: got sel=%b data=%h, expected sel=%b data=%h",
                     tag, opnd_b_sel, opnd_b_data, eb[33:32], eb[31:0]);
        end
    endtask

    task automatic expect_sel(input string tag, input logic [1:0] ga, input logic [1:0] gb);
        n_cmp++;
        if (opnd_a_sel !== ga || opnd_b_sel !== gb) begin
            n_bad++;
            $display("FAIL %s: got sel a=%b b=%b, expected a=%b b=%b", tag, opnd_a_sel, opnd_b_sel, ga, gb);
        end
    endtask

    // Drive just after the rising edge, compare at the falling edge.
    task automatic apply(input string tag,
                         input int sa, input int sb,
                         input bit xwe, input int xd, input bit mwe, input int md);
        @(posedge clk); #0.5;
        src_a_idx = 3'(sa); src_b_idx = 3'(sb);
        rf_a_data = 32'hA000_0000 | 32'(sa); rf_b_data = 32'hB000_0000 | 32'(sb);
        xm_wr_en = xwe; xm_dst_idx = 3'(xd); xm_alu_data = 32'hC0DE_0000 | 32'(xd);
        mw_wr_en = mwe; mw_dst_idx = 3'(md); mw_wb_data = 32'h5EED_0000 | 32'(md);
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        src_a_idx = '0; src_b_idx = '0; rf_a_data = '0; rf_b_data = '0;
        xm_wr_en = 0; xm_dst_idx = '0; xm_alu_data = '0;
        mw_wr_en = 0; mw_dst_idx = '0; mw_wb_data = '0;
        repeat (3) @(posedge clk);
        rst = 0;
        @(negedge clk);
        compare("R5 idle after reset");
        expect_sel("R5 idle selects", 2'b00, 2'b00);

        // R1: back-to-back dependency on operand A
        apply("R1 back-to-back", 3, 1, 1, 3, 0, 0);
        expect_sel("R1 select code", 2'b10, 2'b00);
        // R2: dependency at distance two
        apply("R2 distance two", 4, 2, 0, 0, 1, 4);
        expect_sel("R2 select code", 2'b01, 2'b00);
        // R3: operands pick different sources in one cycle
        apply("R3 split sources", 5, 6, 1, 5, 1, 6);
        expect_sel("R3 select codes", 2'b10, 2'b01);
        apply("R3 B only", 1, 7, 1, 7, 0, 0);
        expect_sel("R3 B forwarded", 2'b00, 2'b10);
        // R4: register 0 never forwarded
        apply("R4 zero dest", 0, 0, 1, 0, 1, 0);
        expect_sel("R4 zero dest selects", 2'b00, 2'b00);
        // R5: no match
        apply("R5 no match", 2, 3, 1, 5, 1, 6);
        expect_sel("R5 passthrough", 2'b00, 2'b00);
        // R6: both stages write the same register
        apply("R6 younger wins", 3, 3, 1, 3, 1, 3);
        expect_sel("R6 younger select", 2'b10, 2'b10);
        // R7: write enable low suppresses forwarding
        apply("R7 disabled writes", 3, 4, 0, 3, 0, 4);
        expect_sel("R7 disabled selects", 2'b00, 2'b00);
        apply("R7 young disabled, old used", 2, 2, 0, 2, 1, 2);
        expect_sel("R7 falls to older", 2'b01, 2'b01);
        // R8: same-cycle response to back-to-back changes
        apply("R8 change 1", 6, 6, 1, 6, 0, 0);
        apply("R8 change 2", 6, 6, 0, 0, 0, 0);
        expect_sel("R8 immediate return", 2'b00, 2'b00);

        for (int i = 0; i < 3000; i++) begin
            apply("R3 random", int'($urandom_range(0, 7)), int'($urandom_range(0, 7)),
                  1'($urandom_range(0, 1)), int'($urandom_range(0, 7)),
                  1'($urandom_range(0, 1)), int'($urandom_range(0, 7)));
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule